// File: doc/BRIEF.md
# Cascadable BCD Decade Counter Chain

This block is a synchronous decimal counter built from identical single-digit stages. Each stage holds one binary-coded-decimal digit that steps 0 through 9 and rolls back to 0 on rising clock edges. A stage can take a new value from a 4-bit parallel input. It has an active-low load select, a shared count enable and a carry enable that arrives from the stage below it. A stage's digit-done flag goes high when that stage holds 9 while its carry enable is high. That flag feeds the carry enable of the next stage up.

The top level chains `DIGITS` stages into one decimal counter. Every stage changes on the same clock edge because the carry into each stage is decided before the edge. The chain exposes a packed digit vector and a chain-level terminal flag taken from the most significant stage. An active-low clear acts without a clock edge and overrides all other inputs. It is the block's only reset.

Top module: `bcd_chain_counter`

## Requirements
- R1: While `clr_n` is low, `count_q` is 0 and `term_cnt` is low at once, with no clock edge needed, whatever the other inputs are.
- R2: When `load_n` is low at a rising edge, every digit takes its 4-bit slice of `load_val` (digit k is bits 4k+3..4k) on that edge, whatever `cnt_en` and `chain_en` are.
- R3: When `load_n` is high, the chain advances on an edge only if `cnt_en` and `chain_en` are both high. Otherwise `count_q` keeps its value.
- R4: A counting edge adds one to the chain's decimal value. A digit at 9 that receives a carry becomes 0, and the digit above it advances on the same edge.
- R5: `term_cnt` is high exactly when `chain_en` is high and every digit equals 9 (binary 1001). It follows `chain_en` without a clock edge.
- R6: A digit holding an illegal code 10 to 15 advances by one on each edge where it has a carry, goes from 15 to 0, and never passes a carry to the digit above it.
- R7: Counting from all nines with both enables high gives all zeros on the next edge.
- R8: With `cnt_en` low, a high `chain_en` does not advance the chain. With `chain_en` low, `term_cnt` stays low and the chain holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Parallel load select, active low |
| cnt_en | input | 1 | Count enable shared by every digit |
| chain_en | input | 1 | Carry enable into the least significant digit |
| load_val | input | 4*DIGITS | Packed parallel load digits, least significant digit in bits 3..0 |
| count_q | output | 4*DIGITS | Packed BCD count, least significant digit in bits 3..0 |
| term_cnt | output | 1 | Chain terminal count |

## Verification
On every cycle, the assertions check four things. The clear forces the output to zero. A load captures the sampled input. A disabled edge leaves the count unchanged. The terminal flag matches the carry enable and an all-nines count, and a terminal edge rolls the count to zero. Some behaviour shows only in the bench scenarios. These are the exact decimal sequence across a full sweep of a three-digit chain, a carry rippling through several digits on one edge, and the stepping of illegal codes. The bench also shows that the clear and the terminal flag respond between clock edges.

// File: rtl/bcd_chain_pkg.sv
package bcd_chain_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] TOP_CODE = 4'd9;

  function automatic logic [DIGIT_W-1:0] digit_inc(input logic [DIGIT_W-1:0] d);
    if (d == TOP_CODE) return '0;
    return d + 1'b1;
  endfunction
endpackage

// File: rtl/bcd_digit_next.sv
module bcd_digit_next
  import bcd_chain_pkg::*;
(
  input  logic               load_n,
  input  logic               step,
  input  logic [DIGIT_W-1:0] din,
  input  logic [DIGIT_W-1:0] cur,
  output logic [DIGIT_W-1:0] nxt
);
  always_comb begin
    if (!load_n)   nxt = din;
    else if (step) nxt = digit_inc(cur);
    else           nxt = cur;
  end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
  import bcd_chain_pkg::*;
(
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic               en_par,
  input  logic               en_trk,
  input  logic [DIGIT_W-1:0] din,
  output logic [DIGIT_W-1:0] q,
  output logic               tc
);
  logic [DIGIT_W-1:0] state_r;
  logic [DIGIT_W-1:0] state_nxt;

  bcd_digit_next u_next (
    .load_n (load_n),
    .step   (en_par & en_trk),
    .din    (din),
    .cur    (state_r),
    .nxt    (state_nxt)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) state_r <= '0;
    else        state_r <= state_nxt;
  end

  assign q  = state_r;
  assign tc = en_trk & (state_r == TOP_CODE);
endmodule

// File: rtl/bcd_chain_counter.sv
module bcd_chain_counter
  import bcd_chain_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       cnt_en,
  input  logic                       chain_en,
  input  logic [DIGITS*DIGIT_W-1:0]  load_val,
  output logic [DIGITS*DIGIT_W-1:0]  count_q,
  output logic                       term_cnt
);
  localparam int VEC_W = DIGITS * DIGIT_W;

  logic [DIGITS:0] carry;
  logic [VEC_W-1:0] q_all;

  assign carry[0] = chain_en;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit u_dig (
      .clk    (clk),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_par (cnt_en),
      .en_trk (carry[g]),
      .din    (load_val[g*DIGIT_W +: DIGIT_W]),
      .q      (q_all[g*DIGIT_W +: DIGIT_W]),
      .tc     (carry[g+1])
    );
  end

  assign count_q  = q_all;
  assign term_cnt = carry[DIGITS];
endmodule

// File: rtl/bcd_chain_chk.sv
module bcd_chain_chk
  import bcd_chain_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input logic                      clk,
  input logic                      clr_n,
  input logic                      load_n,
  input logic                      cnt_en,
  input logic                      chain_en,
  input logic [DIGITS*DIGIT_W-1:0] load_val,
  input logic [DIGITS*DIGIT_W-1:0] count_q,
  input logic                      term_cnt
);
  function automatic logic all_nines(input logic [DIGITS*DIGIT_W-1:0] v);
    logic r;
    r = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (v[i*DIGIT_W +: DIGIT_W] != TOP_CODE) r = 1'b0;
    return r;
  endfunction

  // R1
  clear_zero_chk: assert property (@(posedge clk)
    !clr_n |-> (count_q == '0) && !term_cnt);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count_q == $past(load_val));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && !(cnt_en && chain_en) |=> $stable(count_q));

  // R5
  term_match_chk: assert property (@(posedge clk) disable iff (!clr_n)
    term_cnt == (chain_en && all_nines(count_q)));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!clr_n)
    term_cnt && load_n && cnt_en |=> count_q == '0);
endmodule

bind bcd_chain_counter bcd_chain_chk #(.DIGITS(DIGITS)) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .load_n   (load_n),
  .cnt_en   (cnt_en),
  .chain_en (chain_en),
  .load_val (load_val),
  .count_q  (count_q),
  .term_cnt (term_cnt)
);

// File: tb/bcd_chain_counter_tb.sv
module bcd_chain_counter_tb;
  localparam int N  = 3;
  localparam int W  = N * 4;
  localparam int MOD = 1000;

  logic clk = 1'b0;
  logic clr_n = 1'b0, load_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count_q;
  logic term_cnt;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bcd_chain_counter #(.DIGITS(N)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .load_val(load_val), .count_q(count_q), .term_cnt(term_cnt)
  );

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int ref_v;
    repeat (2) tick();
    check("R1 reset count", 32'(count_q), 0);
    check("R1 reset term", 32'(term_cnt), 0);
    clr_n = 1'b1;

    // R2: load while both enables low
    load_n = 1'b0; load_val = to_bcd(457); tick();
    check("R2 load enables low", 32'(count_q), 32'(to_bcd(457)));
    load_val = to_bcd(0); cnt_en = 1'b1; chain_en = 1'b1; tick();
    check("R2 load enables high", 32'(count_q), 0);
    load_n = 1'b1;

    // R4 R5 R7: full decimal sweep
    ref_v = 0;
    for (int i = 0; i < MOD + 5; i++) begin
      check("R5 term sweep", 32'(term_cnt), 32'(ref_v == MOD - 1));
      tick();
      ref_v = (ref_v + 1) % MOD;
      check(ref_v == 0 ? "R7 all-nines wrap" : "R4 sweep", 32'(count_q), 32'(to_bcd(ref_v)));
    end

    // R3 R8: mixed enables
    for (int i = 0; i < 300; i++) begin
      cnt_en = (i % 3) != 0;
      chain_en = (i % 5) != 1;
      #1;
      check("R8 term gate", 32'(term_cnt), 32'(chain_en && ref_v == MOD - 1));
      tick();
      if (cnt_en && chain_en) ref_v = (ref_v + 1) % MOD;
      check("R3 enable mix", 32'(count_q), 32'(to_bcd(ref_v)));
    end

    // R5: term follows chain_en without an edge
    load_n = 1'b0; load_val = to_bcd(999); cnt_en = 1'b0; chain_en = 1'b0; tick();
    load_n = 1'b1;
    check("R8 term low chain_en low", 32'(term_cnt), 0);
    chain_en = 1'b1; #1;
    check("R5 term combinational", 32'(term_cnt), 1);
    tick();
    check("R8 hold cnt_en low", 32'(count_q), 32'(to_bcd(999)));

    // R6: illegal codes
    load_n = 1'b0; load_val = 12'h00A; tick();
    load_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1;
    for (int c = 11; c <= 16; c++) begin
      tick();
      check("R6 illegal step", 32'(count_q), 32'(c & 15));
      check("R6 illegal no term", 32'(term_cnt), 0);
    end
    load_n = 1'b0; load_val = 12'h0C9; tick(); load_n = 1'b1; tick();
    check("R6 carry into illegal", 32'(count_q), 32'h0D0);
    load_n = 1'b0; load_val = 12'h0F9; tick(); load_n = 1'b1; tick();
    check("R6 illegal 15 no carry", 32'(count_q), 32'h000);

    // R1: clear mid-count, between edges
    load_n = 1'b0; load_val = to_bcd(999); tick(); load_n = 1'b1;
    clr_n = 1'b0; #1;
    check("R1 async clear count", 32'(count_q), 0);
    check("R1 async clear term", 32'(term_cnt), 0);
    load_n = 1'b0; tick();
    check("R1 clear overrides load", 32'(count_q), 0);
    clr_n = 1'b1; load_n = 1'b1; tick();
    check("R4 count after clear", 32'(count_q), 32'(to_bcd(1)));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule